// File: doc/BRIEF.md
# Three-Operand Integer Multiply Unit

This execution unit serves a 64-bit RISC core. It carries out the multiply group that writes one general-purpose destination instead of a hidden accumulator pair. The issue stage hands it the major opcode, the 5-bit sub-field and the function code of an already fetched instruction, the destination index and two 64-bit source operands. Some time later the unit returns either the low or the high half of the product, with a write enable for the register file or a reserved-instruction exception flag.

The product is built over several cycles by an iterative shift-add datapath that consumes `DIGIT_W` multiplier bits per cycle. A start/busy/done handshake governs the unit. A request is taken only while the unit is idle. Once the result is presented, it and its destination stay frozen until the consumer acknowledges them. The 32-bit forms read only the low words of the sources and return a sign-extended 32-bit word. The 64-bit forms can be turned off with a mode input.

Top module: `mulx_unit`

## Requirements
- R1: A request is legal only when major_i is 0, funct_i is one of 0x18 (32-bit signed), 0x19 (32-bit unsigned), 0x1C (64-bit signed) or 0x1D (64-bit unsigned), and shamt_i is 2 or 3. Any other combination completes with rsvd_exc_o=1 and we_o=0.
- R2: shamt_i=2 returns the low half of the product and shamt_i=3 returns the high half.
- R3: The 32-bit forms use only bits 31:0 of each source. They return bits 31:0 (low form) or bits 63:32 (high form) of the 64-bit product, sign-extended to 64 bits, and this applies to the unsigned forms as well.
- R4: For the same operands, the low-half result of a signed form equals that of the matching unsigned form.
- R5: The 64-bit high forms return bits 127:64 of the full 128-bit product, signed for 0x1C and unsigned for 0x1D.
- R6: A legal request with rd_i=0 completes with we_o=0 and rsvd_exc_o=0. An illegal request with rd_i=0 still raises rsvd_exc_o.
- R7: With wide_en_i=0 the 64-bit forms raise rsvd_exc_o. The 32-bit forms are unaffected.
- R8: start_i is accepted only while busy_o is low. busy_o is high from the edge after acceptance until the acknowledge. A start_i pulse while busy has no effect on the result in flight.
- R9: While done_o is high and ack_i is low, done_o, result_o, dst_o, we_o and rsvd_exc_o hold their values. ack_i with done_o releases the unit, and busy_o is low on the next cycle.
- R10: A legal, writing request raises done_o XLEN/DIGIT_W+2 clock edges after the accepting edge, counting that edge. Exceptions and rd_i=0 requests raise done_o after one edge.
- R11: After reset busy_o, done_o, we_o and rsvd_exc_o are 0 and result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken when busy_o is low |
| major_i | input | 6 | Major opcode of the instruction |
| shamt_i | input | 5 | Sub-field selecting the low (2) or high (3) half |
| funct_i | input | 6 | Function code selecting width and signedness |
| rd_i | input | 5 | Destination register index |
| wide_en_i | input | 1 | Enables the 64-bit forms |
| src_a_i | input | XLEN | First source operand |
| src_b_i | input | XLEN | Second source operand |
| ack_i | input | 1 | Consumer acknowledge of a presented result |
| busy_o | output | 1 | Request in flight or result awaiting acknowledge |
| done_o | output | 1 | Result presented |
| we_o | output | 1 | Register-file write enable for the result |
| rsvd_exc_o | output | 1 | Reserved-instruction exception |
| dst_o | output | 5 | Destination index of the presented result |
| result_o | output | XLEN | Result value |

## Verification
The sweep crosses the eight legal forms with operands at zero, one, all-ones, the most negative value, the largest positive value, and words whose upper half is junk. A design that skipped the signed high-half correction would be off by whole operands in the top 64 bits. A design that zero-extended an unsigned 32-bit word, or read the upper source bits in a narrow form, would mismatch in the upper word. Every shift-field value outside 2 and 3, foreign function codes, a non-zero major opcode, and wide forms with wide_en_i low must all raise the exception; a decoder that checked only the function code would write instead. Further runs check that a zero destination suppresses the write but not an exception, that a start pulse mid-run is ignored, that results stay stable while unacknowledged, and the exact completion latency.

// File: rtl/mulx_pkg.sv
package mulx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FMT,
        ST_DONE
    } mulx_state_e;

    // decoded operation attributes
    typedef struct packed {
        logic wide;   // 64-bit form
        logic sgn;    // signed operands
        logic high;   // upper half of the product
    } mul_op_t;

endpackage

// File: rtl/mulx_decode.sv
module mulx_decode
    import mulx_pkg::*;
(
    input  logic [5:0] major_i,
    input  logic [4:0] shamt_i,
    input  logic [5:0] funct_i,
    input  logic       wide_en_i,
    output mul_op_t    op_o,
    output logic       illegal_o
);

    logic known;
    logic sel_ok;

    always_comb begin
        known     = 1'b1;
        op_o.wide = 1'b0;
        op_o.sgn  = 1'b0;
        unique case (funct_i)
            6'h18: begin op_o.wide = 1'b0; op_o.sgn = 1'b1; end
            6'h19: begin op_o.wide = 1'b0; op_o.sgn = 1'b0; end
            6'h1C: begin op_o.wide = 1'b1; op_o.sgn = 1'b1; end
            6'h1D: begin op_o.wide = 1'b1; op_o.sgn = 1'b0; end
            default: known = 1'b0;
        endcase
        sel_ok    = (shamt_i == 5'd2) || (shamt_i == 5'd3);
        op_o.high = shamt_i[0];
        illegal_o = (major_i != 6'd0) || !known || !sel_ok ||
                    (op_o.wide && !wide_en_i);
    end

endmodule

// File: rtl/mulx_step.sv
// One shift-add iteration: accumulates a * (low digit of lo) into hi and
// shifts the pair right by one digit.
module mulx_step #(
    parameter int XLEN    = 64,
    parameter int DIGIT_W = 4
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] hi_i,
    input  logic [XLEN-1:0] lo_i,
    output logic [XLEN-1:0] hi_o,
    output logic [XLEN-1:0] lo_o
);

    localparam int ACC_W = XLEN + DIGIT_W;

    logic [ACC_W-1:0] partial;
    logic [ACC_W-1:0] sum;

    generate
        if (DIGIT_W == 1) begin : g_bit
            assign partial = lo_i[0] ? {1'b0, a_i} : '0;
        end else begin : g_digit
            assign partial = ACC_W'(a_i) * ACC_W'(lo_i[DIGIT_W-1:0]);
        end
    endgenerate

    always_comb begin
        sum  = ACC_W'(hi_i) + partial;
        hi_o = sum[ACC_W-1:DIGIT_W];
        lo_o = {sum[DIGIT_W-1:0], lo_i[XLEN-1:DIGIT_W]};
    end

endmodule

// File: rtl/mulx_format.sv
// Picks the requested half and applies the signed correction for 64-bit forms.
module mulx_format
    import mulx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  mul_op_t         op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [XLEN-1:0] hi_i,
    input  logic [XLEN-1:0] lo_i,
    output logic [XLEN-1:0] res_o
);

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] fix_a;
    logic [XLEN-1:0] fix_b;
    logic [XLEN-1:0] hi_fix;
    logic [HALF-1:0] word;

    always_comb begin
        fix_a  = (op_i.sgn && b_i[XLEN-1]) ? a_i : '0;
        fix_b  = (op_i.sgn && a_i[XLEN-1]) ? b_i : '0;
        hi_fix = hi_i - fix_a - fix_b;
        word   = op_i.high ? lo_i[XLEN-1:HALF] : lo_i[HALF-1:0];
        if (op_i.wide) begin
            res_o = op_i.high ? hi_fix : lo_i;
        end else begin
            res_o = {{HALF{word[HALF-1]}}, word};
        end
    end

endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
    import mulx_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int DIGIT_W = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic [5:0]      major_i,
    input  logic [4:0]      shamt_i,
    input  logic [5:0]      funct_i,
    input  logic [4:0]      rd_i,
    input  logic            wide_en_i,
    input  logic [XLEN-1:0] src_a_i,
    input  logic [XLEN-1:0] src_b_i,
    input  logic            ack_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            we_o,
    output logic            rsvd_exc_o,
    output logic [4:0]      dst_o,
    output logic [XLEN-1:0] result_o
);

    localparam int HALF  = XLEN / 2;
    localparam int STEPS = XLEN / DIGIT_W;
    localparam int CNT_W = $clog2(STEPS + 1);

    typedef struct packed {
        mulx_state_e     st;
        logic [CNT_W-1:0] cnt;
        mul_op_t         op;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] hi;
        logic [XLEN-1:0] lo;
        logic [XLEN-1:0] res;
        logic [4:0]      dst;
        logic            we;
        logic            exc;
    } mulx_regs_t;

    mulx_regs_t r_d, r_q;

    mul_op_t         dec_op;
    logic            dec_illegal;
    logic [XLEN-1:0] step_hi, step_lo;
    logic [XLEN-1:0] fmt_res;
    logic [XLEN-1:0] a_ext, b_ext;

    mulx_decode dec_i (
        .major_i   (major_i),
        .shamt_i   (shamt_i),
        .funct_i   (funct_i),
        .wide_en_i (wide_en_i),
        .op_o      (dec_op),
        .illegal_o (dec_illegal)
    );

    mulx_step #(.XLEN(XLEN), .DIGIT_W(DIGIT_W)) step_i (
        .a_i  (r_q.a),
        .hi_i (r_q.hi),
        .lo_i (r_q.lo),
        .hi_o (step_hi),
        .lo_o (step_lo)
    );

    mulx_format #(.XLEN(XLEN)) fmt_i (
        .op_i  (r_q.op),
        .a_i   (r_q.a),
        .b_i   (r_q.b),
        .hi_i  (r_q.hi),
        .lo_i  (r_q.lo),
        .res_o (fmt_res)
    );

    // narrow forms: extend the low words by signedness so that the low
    // 64 bits of the unsigned product are exact
    always_comb begin
        if (dec_op.wide) begin
            a_ext = src_a_i;
            b_ext = src_b_i;
        end else if (dec_op.sgn) begin
            a_ext = {{HALF{src_a_i[HALF-1]}}, src_a_i[HALF-1:0]};
            b_ext = {{HALF{src_b_i[HALF-1]}}, src_b_i[HALF-1:0]};
        end else begin
            a_ext = {{HALF{1'b0}}, src_a_i[HALF-1:0]};
            b_ext = {{HALF{1'b0}}, src_b_i[HALF-1:0]};
        end
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.dst = rd_i;
                    r_d.op  = dec_op;
                    if (dec_illegal) begin
                        r_d.exc = 1'b1;
                        r_d.we  = 1'b0;
                        r_d.res = '0;
                        r_d.st  = ST_DONE;
                    end else if (rd_i == 5'd0) begin
                        r_d.exc = 1'b0;
                        r_d.we  = 1'b0;
                        r_d.res = '0;
                        r_d.st  = ST_DONE;
                    end else begin
                        r_d.a   = a_ext;
                        r_d.b   = b_ext;
                        r_d.hi  = '0;
                        r_d.lo  = b_ext;
                        r_d.cnt = CNT_W'(STEPS - 1);
                        r_d.st  = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                r_d.hi  = step_hi;
                r_d.lo  = step_lo;
                r_d.cnt = r_q.cnt - 1'b1;
                if (r_q.cnt == '0) begin
                    r_d.st = ST_FMT;
                end
            end
            ST_FMT: begin
                r_d.res = fmt_res;
                r_d.we  = 1'b1;
                r_d.exc = 1'b0;
                r_d.st  = ST_DONE;
            end
            ST_DONE: begin
                if (ack_i) begin
                    r_d.we  = 1'b0;
                    r_d.exc = 1'b0;
                    r_d.st  = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, op: '0, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = (r_q.st == ST_DONE);
    assign we_o       = r_q.we;
    assign rsvd_exc_o = r_q.exc;
    assign dst_o      = r_q.dst;
    assign result_o   = r_q.res;

endmodule

// File: rtl/mulx_checker.sv
module mulx_checker #(
    parameter int XLEN = 64
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            start_i,
    input logic            ack_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            we_o,
    input logic            rsvd_exc_o,
    input logic [4:0]      dst_o,
    input logic [XLEN-1:0] result_o
);

    a_r8_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o);

    a_r8_done_within_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> busy_o);

    a_r9_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !ack_i) |=> (done_o && $stable(result_o) && $stable(dst_o) &&
                                $stable(we_o) && $stable(rsvd_exc_o)));

    a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && ack_i) |=> !busy_o);

    a_r1_exc_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !(we_o && rsvd_exc_o));

    a_r6_no_write_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && we_o) |-> (dst_o != 5'd0));

    a_r11_flags_only_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_o || rsvd_exc_o) |-> done_o);

endmodule

bind mulx_unit mulx_checker #(.XLEN(XLEN)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ack_i      (ack_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .we_o       (we_o),
    .rsvd_exc_o (rsvd_exc_o),
    .dst_o      (dst_o),
    .result_o   (result_o)
);

// File: tb/mulx_unit_tb_top.sv
`timescale 1ns/1ps
module mulx_unit_tb_top;

    localparam int XLEN    = 64;
    localparam int DIGIT_W = 4;
    localparam int STEPS   = XLEN / DIGIT_W;

    logic            clk_i = 1'b0;
    logic            rst_ni = 1'b0;
    logic            start_i = 1'b0;
    logic [5:0]      major_i = '0;
    logic [4:0]      shamt_i = '0;
    logic [5:0]      funct_i = '0;
    logic [4:0]      rd_i = '0;
    logic            wide_en_i = 1'b1;
    logic [XLEN-1:0] src_a_i = '0;
    logic [XLEN-1:0] src_b_i = '0;
    logic            ack_i = 1'b0;
    logic            busy_o, done_o, we_o, rsvd_exc_o;
    logic [4:0]      dst_o;
    logic [XLEN-1:0] result_o;

    int n_vec  = 0;
    int n_fail = 0;

    always #2 clk_i = ~clk_i;

    mulx_unit #(.XLEN(XLEN), .DIGIT_W(DIGIT_W)) dut_i (
        .clk_i, .rst_ni, .start_i, .major_i, .shamt_i, .funct_i, .rd_i,
        .wide_en_i, .src_a_i, .src_b_i, .ack_i,
        .busy_o, .done_o, .we_o, .rsvd_exc_o, .dst_o, .result_o
    );

    function automatic logic [63:0] ref_result(input logic [5:0] fn, input logic [4:0] sh,
                                               input logic [63:0] a, input logic [63:0] b);
        logic [127:0] pa, pb, p;
        logic [63:0]  na, nb, np;
        logic [31:0]  w;
        logic sgn = !fn[0];
        if (fn[2]) begin
            pa = sgn ? {{64{a[63]}}, a} : {64'd0, a};
            pb = sgn ? {{64{b[63]}}, b} : {64'd0, b};
            p  = pa * pb;
            return sh[0] ? p[127:64] : p[63:0];
        end
        na = sgn ? {{32{a[31]}}, a[31:0]} : {32'd0, a[31:0]};
        nb = sgn ? {{32{b[31]}}, b[31:0]} : {32'd0, b[31:0]};
        np = na * nb;
        w  = sh[0] ? np[63:32] : np[31:0];
        return {{32{w[31]}}, w};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // issues one request and checks outcome, latency and release
    task automatic run_op(input logic [5:0] mj, input logic [4:0] sh, input logic [5:0] fn,
                          input logic [4:0] rd, input logic wen, input logic [63:0] a,
                          input logic [63:0] b, input string tag, output logic [63:0] got);
        logic exp_exc, exp_we;
        logic [63:0] exp_res;
        int edges;
        exp_exc = (mj != 0) || !(fn == 6'h18 || fn == 6'h19 || fn == 6'h1C || fn == 6'h1D) ||
                  !(sh == 5'd2 || sh == 5'd3) || (fn[2] && !wen);
        exp_we  = !exp_exc && (rd != 0);
        exp_res = ref_result(fn, sh, a, b);
        major_i = mj; shamt_i = sh; funct_i = fn; rd_i = rd; wide_en_i = wen;
        src_a_i = a; src_b_i = b; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        edges = 1;
        while (!done_o && edges < 200) begin
            @(negedge clk_i);
            edges++;
        end
        got = result_o;
        check(rsvd_exc_o == exp_exc && we_o == exp_we && dst_o == rd,
              {tag, " R1/R6/R7 flags"}, {rsvd_exc_o, we_o, dst_o}, {exp_exc, exp_we, rd});
        if (exp_we)
            check(result_o == exp_res, {tag, " R2/R3/R5 value"}, result_o, exp_res);
        check(edges == (exp_we ? STEPS + 2 : 1), "R10 latency", 64'(edges),
              64'(exp_we ? STEPS + 2 : 1));
        ack_i = 1'b1;
        @(negedge clk_i);
        ack_i = 1'b0;
        if (busy_o) check(1'b0, "R9 release", 64'(busy_o), 64'd0);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] corners [8];
        logic [5:0]  fns [4];
        logic [63:0] g1, g2;
        corners[0] = 64'd0;
        corners[1] = 64'd1;
        corners[2] = '1;
        corners[3] = 64'h8000_0000_0000_0000;
        corners[4] = 64'h7FFF_FFFF_FFFF_FFFF;
        corners[5] = 64'h0000_0000_8000_0000;
        corners[6] = 64'h0000_0000_FFFF_FFFF;
        corners[7] = 64'hDEAD_BEEF_7654_3211;
        fns[0] = 6'h18; fns[1] = 6'h19; fns[2] = 6'h1C; fns[3] = 6'h1D;

        repeat (3) @(negedge clk_i);
        // R11 reset state
        check(!busy_o && !done_o && !we_o && !rsvd_exc_o && result_o == 0,
              "R11 reset", result_o, 64'd0);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R2 R3 R5: all forms across corner operands
        for (int f = 0; f < 4; f++)
            for (int s = 2; s < 4; s++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++)
                        run_op(6'd0, 5'(s), fns[f], 5'd7, 1'b1, corners[i], corners[j],
                               "sweep", g1);

        // random operands
        for (int k = 0; k < 200; k++)
            run_op(6'd0, 5'(2 + (k % 2)), fns[(k / 2) % 4], 5'(1 + k % 31), 1'b1,
                   {$urandom, $urandom}, {$urandom, $urandom}, "random", g1);

        // R4: low halves agree between signed and unsigned forms
        for (int w = 0; w < 2; w++)
            for (int i = 2; i < 8; i++) begin
                run_op(6'd0, 5'd2, w ? 6'h1C : 6'h18, 5'd3, 1'b1, corners[i], corners[9 - i],
                       "R4 signed", g1);
                run_op(6'd0, 5'd2, w ? 6'h1D : 6'h19, 5'd3, 1'b1, corners[i], corners[9 - i],
                       "R4 unsigned", g2);
                check(g1 == g2, "R4 low equal", g2, g1);
            end

        // R1: every other shift-field value, foreign functions, foreign major
        for (int f = 0; f < 4; f++)
            for (int s = 0; s < 32; s++)
                if (s != 2 && s != 3)
                    run_op(6'd0, 5'(s), fns[f], 5'd5, 1'b1, corners[2], corners[2],
                           "R1 shamt", g1);
        run_op(6'd0, 5'd2, 6'h1A, 5'd5, 1'b1, 64'd9, 64'd3, "R1 funct", g1);
        run_op(6'd0, 5'd3, 6'h1B, 5'd5, 1'b1, 64'd9, 64'd3, "R1 funct", g1);
        run_op(6'd0, 5'd2, 6'h1E, 5'd5, 1'b1, 64'd9, 64'd3, "R1 funct", g1);
        run_op(6'h1C, 5'd2, 6'h18, 5'd5, 1'b1, 64'd9, 64'd3, "R1 major", g1);

        // R7: wide forms disabled, narrow forms still legal
        for (int f = 0; f < 4; f++)
            run_op(6'd0, 5'd3, fns[f], 5'd9, 1'b0, corners[3], corners[7], "R7", g1);

        // R6: zero destination
        run_op(6'd0, 5'd2, 6'h18, 5'd0, 1'b1, 64'd5, 64'd6, "R6 nop", g1);
        run_op(6'd0, 5'd3, 6'h1D, 5'd0, 1'b1, 64'd5, 64'd6, "R6 nop", g1);
        run_op(6'd0, 5'd4, 6'h18, 5'd0, 1'b1, 64'd5, 64'd6, "R6 illegal", g1);
        run_op(6'd0, 5'd2, 6'h1C, 5'd0, 1'b0, 64'd5, 64'd6, "R6 wide off", g1);

        // R8 R9: start while busy is ignored, result held until ack
        major_i = 0; shamt_i = 5'd2; funct_i = 6'h1C; rd_i = 5'd11; wide_en_i = 1'b1;
        src_a_i = 64'd1000; src_b_i = 64'd77; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        check(busy_o, "R8 busy", 64'(busy_o), 64'd1);
        repeat (3) @(negedge clk_i);
        shamt_i = 5'd3; funct_i = 6'h19; rd_i = 5'd20; src_a_i = '1; src_b_i = '1;
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        while (!done_o) @(negedge clk_i);
        check(result_o == 64'd77000 && dst_o == 5'd11 && we_o, "R8 ignored start",
              result_o, 64'd77000);
        for (int h = 0; h < 5; h++) begin
            @(negedge clk_i);
            check(done_o && result_o == 64'd77000 && dst_o == 5'd11 && busy_o,
                  "R9 hold", result_o, 64'd77000);
        end
        ack_i = 1'b1;
        @(negedge clk_i);
        ack_i = 1'b0;
        check(!busy_o && !done_o, "R9 release", 64'(busy_o), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule